// File: doc/BRIEF.md
# Digit-Serial Multi-Cycle Adder

This block adds two wide unsigned operands and a carry-in with one narrow adder slice that is reused over several clock cycles. A start strobe captures both operands and the carry-in into internal registers. On each following cycle the block adds one slice of each captured operand and the carry kept from the cycle before, starting with the least significant slice. It writes that slice of the sum into its own position in the result register and keeps the slice's carry-out for the next cycle.

After the most significant slice has been added, the block raises `done_o` for one cycle. At that point it presents the full sum and the final carry-out, and it holds them until the next accepted start. The slice width can be set to any divisor of the total width, from one bit up to the total width, and the latency is the total width divided by the slice width. A slice width that does not divide the total width stops elaboration with an error.

Top module: `serial_adder`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `carry_o` and every bit of `sum_o` are 0.
- R2: With the default widths (32-bit total, 8-bit slice), `{carry_o, sum_o}` equals the 33-bit value `a + b + carry_in` of the captured operands in the cycle where `done_o` is 1.
- R3: With the default widths, a start accepted at clock edge E makes `done_o` 1 in the cycle after edge E+4, so four add cycles are used. `busy_o` is 1 from edge E until that edge.
- R4: With a 2-bit slice, the same 32-bit addition finishes after 16 add cycles and gives the correct 33-bit result.
- R5: With a 16-bit slice, the same 32-bit addition finishes after 2 add cycles and gives the correct 33-bit result.
- R6: The captured carry-in enters the lowest slice, and the carry rippled out of the top slice appears on `carry_o`. For example, all-ones plus zero with carry-in 1 gives sum 0 and carry-out 1, and all-ones plus all-ones with carry-in 1 gives all-ones and carry-out 1.
- R7: `done_o` is 1 for exactly one cycle per accepted start. `busy_o` is 0 in that cycle.
- R8: A start strobe that arrives while `busy_o` is 1 is ignored. The running addition keeps its latency and its result.
- R9: Operand and carry-in inputs are sampled only on an accepted start. Changes to them during the addition do not change the result.
- R10: While the block is idle and no start is asserted, `sum_o` and `carry_o` keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, accepted only while idle |
| a_i | input | TOTAL_W | First operand |
| b_i | input | TOTAL_W | Second operand |
| carry_i | input | 1 | Carry into the lowest slice |
| busy_o | output | 1 | High while slices are being added |
| done_o | output | 1 | One-cycle pulse when the result is complete |
| sum_o | output | TOTAL_W | Result register |
| carry_o | output | 1 | Carry out of the top slice, valid from `done_o` |

## Verification
The checker assumes that operands are unsigned and that a start strobe may arrive at any cycle, including while the block is busy. It also assumes the only reset is the asynchronous one. The checker captures its own copy of the operands on every start it sees accepted, and compares against that copy. The stimulus therefore drives random operands on every busy cycle and sometimes raises start in the middle of an addition, so that the ignore and capture rules are exercised without going outside those assumptions. Three copies of the block with 8-bit, 2-bit and 16-bit slices run the same operations side by side.

// File: rtl/sadd_pkg.sv
package sadd_pkg;

    typedef enum logic [0:0] {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

endpackage

// File: rtl/sadd_slice.sv
// Combinational slice adder: W-bit sum with carry in and carry out.
module sadd_slice #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         c_i,
    output logic [W-1:0] s_o,
    output logic         c_o
);

    logic [W:0] full;

    assign full = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, c_i};
    assign s_o  = full[W-1:0];
    assign c_o  = full[W];

endmodule

// File: rtl/sadd_pick.sv
// Selects one SLICE_W-wide section of a TOTAL_W vector by index.
module sadd_pick #(
    parameter int TOTAL_W = 32,
    parameter int SLICE_W = 8,
    parameter int IDX_W   = 2
) (
    input  logic [TOTAL_W-1:0] vec_i,
    input  logic [IDX_W-1:0]   idx_i,
    output logic [SLICE_W-1:0] slice_o
);

    localparam int NSLICE = TOTAL_W / SLICE_W;

    logic [SLICE_W-1:0] parts [NSLICE];

    for (genvar g = 0; g < NSLICE; g++) begin : g_part
        assign parts[g] = vec_i[g*SLICE_W +: SLICE_W];
    end

    assign slice_o = parts[idx_i];

endmodule

// File: rtl/serial_adder.sv
// Digit-serial adder: one SLICE_W adder reused TOTAL_W/SLICE_W times.
module serial_adder #(
    parameter int TOTAL_W = 32,
    parameter int SLICE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [TOTAL_W-1:0] a_i,
    input  logic [TOTAL_W-1:0] b_i,
    input  logic               carry_i,
    output logic               busy_o,
    output logic               done_o,
    output logic [TOTAL_W-1:0] sum_o,
    output logic               carry_o
);

    import sadd_pkg::*;

    localparam int NSLICE = TOTAL_W / SLICE_W;
    localparam int IDX_W  = (NSLICE > 1) ? $clog2(NSLICE) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NSLICE - 1);

    if (SLICE_W < 1 || (TOTAL_W % SLICE_W) != 0) begin : g_bad_width
        $error("serial_adder: TOTAL_W must be a whole multiple of SLICE_W");
    end

    typedef struct packed {
        phase_e             phase;
        logic [IDX_W-1:0]   idx;
        logic               carry;
        logic [TOTAL_W-1:0] a;
        logic [TOTAL_W-1:0] b;
        logic [TOTAL_W-1:0] sum;
        logic               cout;
        logic               done;
    } state_t;

    state_t st_d, st_q;

    logic [SLICE_W-1:0] a_sl_d, b_sl_d, s_sl_d;
    logic               c_sl_d;

    sadd_pick #(.TOTAL_W(TOTAL_W), .SLICE_W(SLICE_W), .IDX_W(IDX_W)) u_pick_a (
        .vec_i   (st_q.a),
        .idx_i   (st_q.idx),
        .slice_o (a_sl_d)
    );

    sadd_pick #(.TOTAL_W(TOTAL_W), .SLICE_W(SLICE_W), .IDX_W(IDX_W)) u_pick_b (
        .vec_i   (st_q.b),
        .idx_i   (st_q.idx),
        .slice_o (b_sl_d)
    );

    sadd_slice #(.W(SLICE_W)) u_slice (
        .a_i (a_sl_d),
        .b_i (b_sl_d),
        .c_i (st_q.carry),
        .s_o (s_sl_d),
        .c_o (c_sl_d)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    st_d.phase = PH_RUN;
                    st_d.idx   = '0;
                    st_d.carry = carry_i;
                    st_d.a     = a_i;
                    st_d.b     = b_i;
                end
            end
            PH_RUN: begin
                st_d.sum[st_q.idx*SLICE_W +: SLICE_W] = s_sl_d;
                st_d.carry = c_sl_d;
                if (st_q.idx == LAST_IDX) begin
                    st_d.phase = PH_IDLE;
                    st_d.done  = 1'b1;
                    st_d.cout  = c_sl_d;
                end else begin
                    st_d.idx = st_q.idx + 1'b1;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o  = (st_q.phase == PH_RUN);
    assign done_o  = st_q.done;
    assign sum_o   = st_q.sum;
    assign carry_o = st_q.cout;

endmodule

// File: rtl/sadd_checker.sv
// Port-level properties of serial_adder, attached by bind.
module sadd_checker #(
    parameter int TOTAL_W = 32,
    parameter int SLICE_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start_i,
    input logic [TOTAL_W-1:0] a_i,
    input logic [TOTAL_W-1:0] b_i,
    input logic               carry_i,
    input logic               busy_o,
    input logic               done_o,
    input logic [TOTAL_W-1:0] sum_o,
    input logic               carry_o
);

    localparam int NSLICE = TOTAL_W / SLICE_W;
    localparam int CNT_W  = $clog2(NSLICE + 1) + 1;

    logic [CNT_W-1:0]   run_cnt;
    logic [TOTAL_W-1:0] cap_a, cap_b;
    logic               cap_c;
    logic               accept;

    assign accept = start_i && !busy_o;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
            cap_a   <= '0;
            cap_b   <= '0;
            cap_c   <= 1'b0;
        end else if (accept) begin
            run_cnt <= '0;
            cap_a   <= a_i;
            cap_b   <= b_i;
            cap_c   <= carry_i;
        end else if (busy_o) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    // R2 R4 R5 R6 R9: result matches the operands seen at the accepted start
    a_r2_result: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ({carry_o, sum_o} ==
                    ({1'b0, cap_a} + {1'b0, cap_b} + {{TOTAL_W{1'b0}}, cap_c})));

    // R3: done arrives exactly after NSLICE busy cycles
    a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (run_cnt == CNT_W'(NSLICE)));

    a_r3_busy_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (run_cnt < CNT_W'(NSLICE)));

    // R7: single-cycle done, never while busy
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R8: busy is not cut short by anything, including a new start
    a_r8_keep_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && run_cnt != CNT_W'(NSLICE - 1)) |=> busy_o);

    // R10: idle without start holds the result
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(sum_o) && $stable(carry_o)));

endmodule

bind serial_adder sadd_checker #(.TOTAL_W(TOTAL_W), .SLICE_W(SLICE_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .a_i     (a_i),
    .b_i     (b_i),
    .carry_i (carry_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .sum_o   (sum_o),
    .carry_o (carry_o)
);

// File: tb/tb_serial_adder.sv
`timescale 1ns/1ps
module tb_serial_adder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] a_i = '0, b_i = '0;
    logic        carry_i = 1'b0;

    logic        busy8, done8, cout8;
    logic [31:0] sum8;
    logic        busy2, done2, cout2;
    logic [31:0] sum2;
    logic        busy16, done16, cout16;
    logic [31:0] sum16;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    serial_adder #(.TOTAL_W(32), .SLICE_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .a_i(a_i), .b_i(b_i),
        .carry_i(carry_i), .busy_o(busy8), .done_o(done8), .sum_o(sum8), .carry_o(cout8));

    serial_adder #(.TOTAL_W(32), .SLICE_W(2)) dut_s2 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .a_i(a_i), .b_i(b_i),
        .carry_i(carry_i), .busy_o(busy2), .done_o(done2), .sum_o(sum2), .carry_o(cout2));

    serial_adder #(.TOTAL_W(32), .SLICE_W(16)) dut_s16 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .a_i(a_i), .b_i(b_i),
        .carry_i(carry_i), .busy_o(busy16), .done_o(done16), .sum_o(sum16), .carry_o(cout16));

    function automatic logic [32:0] ref_add(logic [31:0] a, logic [31:0] b, logic c);
        return {1'b0, a} + {1'b0, b} + {32'd0, c};
    endfunction

    task automatic chk(bit ok, string req, string what, logic [32:0] act, logic [32:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_unit(int k, int lat, string lat_tag, string res_tag,
                              logic done, logic busy, logic [32:0] got,
                              logic [32:0] exp, bit poked);
        if (k == lat - 1)
            chk(busy == 1'b1 && done == 1'b0, poked ? "R8" : lat_tag,
                "busy before last slice", {31'd0, busy, done}, 33'd2);
        if (k == lat) begin
            chk(done == 1'b1 && busy == 1'b0, lat_tag, "done at latency",
                {31'd0, busy, done}, 33'd1);
            chk(got == exp, res_tag, "result", got, exp);
        end
        if (k == lat + 1)
            chk(done == 1'b0, "R7", "done single pulse", {32'd0, done}, 33'd0);
    endtask

    // One addition on all three instances; scrambles inputs while busy (R9)
    task automatic run_op(logic [31:0] a, logic [31:0] b, logic c, bit poke, string tag);
        logic [32:0] exp;
        exp = ref_add(a, b, c);
        @(negedge clk);
        a_i = a; b_i = b; carry_i = c; start_i = 1'b1;
        for (int k = 0; k <= 17; k++) begin
            @(negedge clk);
            start_i = (poke && k == 1);
            a_i = $urandom; b_i = $urandom; carry_i = 1'($urandom);
            check_unit(k, 4,  "R3", tag,  done8,  busy8,  {cout8, sum8},   exp, poke);
            check_unit(k, 16, "R4", "R4", done2,  busy2,  {cout2, sum2},   exp, poke);
            check_unit(k, 2,  "R5", "R5", done16, busy16, {cout16, sum16}, exp, poke);
            if (poke && k == 3 && tag == "R2")
                chk(busy8 == 1'b1, "R8", "start during run ignored", {32'd0, busy8}, 33'd1);
        end
        // idle with start low: result must be held (R10)
        start_i = 1'b0;
        repeat (2) begin
            @(negedge clk);
            a_i = $urandom; b_i = $urandom;
        end
        chk({cout8, sum8} == exp, "R10", "hold while idle", {cout8, sum8}, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        chk({busy8, done8, cout8, sum8} == 35'd0 ? 1'b1 : 1'b0, "R1", "reset state",
            {cout8, sum8}, 33'd0);
        chk(busy2 == 1'b0 && done16 == 1'b0, "R1", "reset flags", {31'd0, busy2, done16}, 33'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy8, done8} == 2'b00, "R1", "idle after reset", {31'd0, busy8, done8}, 33'd0);

        // directed carry corners (R6)
        run_op(32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 1'b0, "R6");
        run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b0, "R6");
        run_op(32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0, "R2");
        run_op(32'h00FF_00FF, 32'h0001_0001, 1'b0, 1'b1, "R2");
        run_op(32'h8000_0000, 32'h8000_0000, 1'b0, 1'b0, "R6");

        // random operands with occasional start during the run (R8, R9)
        for (int i = 0; i < 150; i++) begin
            run_op($urandom, $urandom, 1'($urandom), 1'(($urandom % 4) == 0), "R2");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule